// File: doc/BRIEF.md
# Eight-Bit Subtract and Compare Status Flag Unit

This block does the subtract side of an 8-bit datapath and keeps the status register that goes with it. An operation select picks one of four operations: plain subtract, subtract with borrow, compare, or compare with borrow. The block forms the difference of two operand bytes and returns it as a combinational result. On the next clock edge it updates six arithmetic flags in the status register. The two borrow-chained operations also subtract the carry bit already held in the register. This lets a multi-byte subtract or compare be done one byte at a time, from the least significant byte upwards.

A compare produces the same flags as the matching subtract. It does not raise the result write enable, so the destination keeps its value. The register can also be loaded with a whole byte through a direct write port. That port is the only way to change the two top bits, which hold the interrupt enable and the bit-copy store.

Top module: `status_flag_unit`

## Requirements
- R1: After reset, and before any write or operation, the status register `sreg_o` reads 0x00.
- R2: `res_o` is combinational and equals (rd_i - rr_i - cin) modulo 256. The operation select codes are 00 subtract, 01 subtract with borrow, 10 compare, 11 compare with borrow. `cin` is status bit 0 for codes 01 and 11, and 0 for codes 00 and 10.
- R3: After an operation, status bit 0 (C) is 1 exactly when the full-precision rd_i - rr_i - cin is negative.
- R4: After an operation, status bit 5 (H) is 1 exactly when rd_i[3:0] - rr_i[3:0] - cin is negative.
- R5: After an operation, status bit 3 (V) is 1 exactly when the signed difference of the operands, minus cin, lies outside -128..127.
- R6: After an operation, status bit 2 (N) equals result bit 7, and status bit 4 (S) equals N XOR V.
- R7: For codes 00 and 10, status bit 1 (Z) is 1 exactly when the result is zero.
- R8: For codes 01 and 11, Z is 1 only when the result is zero and Z was already 1 before the operation.
- R9: `res_we_o` is 1 only while `op_valid_i` is 1 and the code is 00 or 01. Compares never raise it.
- R10: Status bits 7 (I) and 6 (T) keep their values across every operation.
- R11: A direct write loads `sr_data_i` into all eight status bits on the next edge. It takes priority over an operation issued in the same cycle.
- R12: With neither `op_valid_i` nor `sr_wr_i` asserted, the status register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation strobe; flags update at the next edge |
| op_sel_i | input | 2 | Operation select (00 sub, 01 sub with borrow, 10 cmp, 11 cmp with borrow) |
| rd_i | input | 8 | Destination operand (minuend) |
| rr_i | input | 8 | Source operand (subtrahend) |
| sr_wr_i | input | 1 | Direct status register write strobe |
| sr_data_i | input | 8 | Direct status register write data |
| res_o | output | 8 | Difference byte |
| res_we_o | output | 1 | Result write-back enable |
| sreg_o | output | 8 | Status register, I T H S V N Z C from bit 7 down to bit 0 |

## Verification
All four operations are swept over a grid of operand bytes in steps of five, with extra values around 0x00, 0x7F/0x80 and 0xFE/0xFF added. Each point runs from three preloaded status values. The preload with C set tells the borrow-chained codes apart from the plain ones. The preloads with Z set and with Z clear tell the chained zero rule from the plain one. The preloads with I and T set or clear show whether arithmetic ever disturbs those bits. The operand edges exercise signed overflow in both directions, a nibble borrow without a byte borrow, and a borrow-in that turns a zero result into 0xFF. Separate cycles pit a direct write against an operation in the same cycle, and hold the register idle.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [1:0] {
    OP_SUB = 2'b00,
    OP_SBC = 2'b01,
    OP_CMP = 2'b10,
    OP_CPC = 2'b11
  } op_e;

  localparam int unsigned SR_W  = 8;
  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_T = 6;
  localparam int unsigned BIT_H = 5;
  localparam int unsigned BIT_S = 4;
  localparam int unsigned BIT_V = 3;
  localparam int unsigned BIT_N = 2;
  localparam int unsigned BIT_Z = 1;
  localparam int unsigned BIT_C = 0;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/sfu_diff.sv
module sfu_diff #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] diff_o
);
  always_comb diff_o = a_i - b_i - {{(DW-1){1'b0}}, cin_i};
endmodule

// File: rtl/sfu_flag_calc.sv
module sfu_flag_calc
  import sfu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] r_i,
  input  logic          chain_i,
  input  logic          z_old_i,
  output flags_t        flags_o
);
  localparam int unsigned MSB = DW - 1;
  localparam int unsigned HB  = DW / 2 - 1;

  logic [DW-1:0] brw_vec;
  logic [DW-1:0] ovf_vec;
  logic          r_zero;

  always_comb begin
    // borrow out of each bit position
    brw_vec = (~a_i & b_i) | (b_i & r_i) | (r_i & ~a_i);
    ovf_vec = (a_i & ~b_i & ~r_i) | (~a_i & b_i & r_i);
    r_zero  = (r_i == '0);
    flags_o.c = brw_vec[MSB];
    flags_o.h = brw_vec[HB];
    flags_o.v = ovf_vec[MSB];
    flags_o.n = r_i[MSB];
    flags_o.s = r_i[MSB] ^ ovf_vec[MSB];
    flags_o.z = chain_i ? (r_zero & z_old_i) : r_zero;
  end
endmodule

// File: rtl/sfu_sreg.sv
module sfu_sreg
  import sfu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  flags_t          flags_i,
  input  logic            wr_i,
  input  logic [SR_W-1:0] wr_data_i,
  output logic [SR_W-1:0] sreg_o
);
  logic [SR_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
    end else if (wr_i) begin
      sreg_q <= wr_data_i;
    end else if (upd_i) begin
      sreg_q[BIT_H] <= flags_i.h;
      sreg_q[BIT_S] <= flags_i.s;
      sreg_q[BIT_V] <= flags_i.v;
      sreg_q[BIT_N] <= flags_i.n;
      sreg_q[BIT_Z] <= flags_i.z;
      sreg_q[BIT_C] <= flags_i.c;
    end
  end

  assign sreg_o = sreg_q;

  p_rst_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> sreg_q == '0);
  p_it_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i) |=> (sreg_q[BIT_I] == $past(sreg_q[BIT_I]) &&
                          sreg_q[BIT_T] == $past(sreg_q[BIT_T])));
  p_wr_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> sreg_q == $past(wr_data_i));
  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !wr_i) |=> $stable(sreg_q));
  p_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i) |=> sreg_q[BIT_S] == (sreg_q[BIT_N] ^ sreg_q[BIT_V]));
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [1:0]      op_sel_i,
  input  logic [DW-1:0]   rd_i,
  input  logic [DW-1:0]   rr_i,
  input  logic            sr_wr_i,
  input  logic [SR_W-1:0] sr_data_i,
  output logic [DW-1:0]   res_o,
  output logic            res_we_o,
  output logic [SR_W-1:0] sreg_o
);
  op_e    op;
  logic   chain;
  logic   is_cmp;
  logic   cin;
  flags_t flags;

  always_comb begin
    op     = op_e'(op_sel_i);
    chain  = (op == OP_SBC) || (op == OP_CPC);
    is_cmp = (op == OP_CMP) || (op == OP_CPC);
    cin    = chain & sreg_o[BIT_C];
  end

  sfu_diff #(.DW(DW)) u_diff (
    .a_i    (rd_i),
    .b_i    (rr_i),
    .cin_i  (cin),
    .diff_o (res_o)
  );

  sfu_flag_calc #(.DW(DW)) u_flags (
    .a_i     (rd_i),
    .b_i     (rr_i),
    .r_i     (res_o),
    .chain_i (chain),
    .z_old_i (sreg_o[BIT_Z]),
    .flags_o (flags)
  );

  sfu_sreg u_sreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (op_valid_i),
    .flags_i   (flags),
    .wr_i      (sr_wr_i),
    .wr_data_i (sr_data_i),
    .sreg_o    (sreg_o)
  );

  assign res_we_o = op_valid_i & ~is_cmp;

  p_cmp_no_we_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_sel_i[1] |-> !res_we_o);
  p_z_chain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !sr_wr_i && op_sel_i[0] && !sreg_o[BIT_Z]) |=> !sreg_o[BIT_Z]);
endmodule

// File: tb/status_flag_unit_bench.sv
module status_flag_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [7:0] rd = '0;
  logic [7:0] rr = '0;
  logic       sr_wr = 1'b0;
  logic [7:0] sr_data = '0;
  logic [7:0] res;
  logic       res_we;
  logic [7:0] sreg;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  status_flag_unit u_status_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_sel_i(op_sel),
    .rd_i(rd), .rr_i(rr), .sr_wr_i(sr_wr), .sr_data_i(sr_data),
    .res_o(res), .res_we_o(res_we), .sreg_o(sreg)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h (op=%0d rd=%0h rr=%0h)", req, got, exp, op_sel, rd, rr);
    end
  endtask

  function automatic logic [7:0] pick(int k);
    case (k)
      52: return 8'h01;
      53: return 8'h7F;
      54: return 8'h80;
      55: return 8'h81;
      56: return 8'hFE;
      default: return 8'(k * 5);
    endcase
  endfunction

  task automatic run_case(logic [7:0] pre, logic [1:0] op, logic [7:0] a, logic [7:0] b);
    int cin, full, lo, sd;
    logic [7:0] r;
    logic c_e, h_e, v_e, n_e, z_e;
    cin  = (op[0] && pre[0]) ? 1 : 0;
    full = int'(a) - int'(b) - cin;
    lo   = int'(a[3:0]) - int'(b[3:0]) - cin;
    sd   = int'($signed(a)) - int'($signed(b)) - cin;
    r    = 8'(full);
    c_e  = full < 0;
    h_e  = lo < 0;
    v_e  = (sd < -128) || (sd > 127);
    n_e  = r[7];
    z_e  = op[0] ? ((r == 0) && pre[1]) : (r == 0);
    @(negedge clk);
    sr_wr = 1'b1; sr_data = pre; op_valid = 1'b0;
    @(negedge clk);
    sr_wr = 1'b0; op_valid = 1'b1; op_sel = op; rd = a; rr = b;
    #2;
    chk("R2 result", int'(res), int'(r));
    chk("R9 write enable", int'(res_we), op[1] ? 0 : 1);
    @(posedge clk);
    #2;
    op_valid = 1'b0;
    chk("R3 C flag", int'(sreg[0]), int'(c_e));
    chk("R4 H flag", int'(sreg[5]), int'(h_e));
    chk("R5 V flag", int'(sreg[3]), int'(v_e));
    chk("R6 N flag", int'(sreg[2]), int'(n_e));
    chk("R6 S flag", int'(sreg[4]), int'(n_e ^ v_e));
    if (op[0]) chk("R8 chained Z", int'(sreg[1]), int'(z_e));
    else       chk("R7 plain Z", int'(sreg[1]), int'(z_e));
    chk("R10 I/T bits", int'(sreg[7:6]), int'(pre[7:6]));
  endtask

  initial begin
    logic [7:0] pres [3];
    logic [7:0] held;
    pres[0] = 8'h00; pres[1] = 8'hC3; pres[2] = 8'h42;
    #5;
    chk("R1 reset value", int'(sreg), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(sreg), 0);
    chk("R9 idle write enable", int'(res_we), 0);

    for (int p = 0; p < 3; p++)
      for (int op = 0; op < 4; op++)
        for (int i = 0; i < 57; i++)
          for (int j = 0; j < 57; j++)
            run_case(pres[p], 2'(op), pick(i), pick(j));

    // R11: direct write beats a simultaneous operation
    @(negedge clk);
    sr_wr = 1'b1; sr_data = 8'h5A; op_valid = 1'b1; op_sel = 2'b00; rd = 8'h00; rr = 8'h01;
    @(negedge clk);
    sr_wr = 1'b0; op_valid = 1'b0;
    chk("R11 write priority", int'(sreg), 8'h5A);
    @(negedge clk);
    sr_wr = 1'b1; sr_data = 8'hA5;
    @(negedge clk);
    sr_wr = 1'b0;
    chk("R11 full byte load", int'(sreg), 8'hA5);

    // R12: idle cycles with changing operands keep the register
    held = sreg;
    for (int k = 0; k < 4; k++) begin
      rd = 8'(k * 37); rr = 8'(255 - k * 11); op_sel = 2'(k);
      @(negedge clk);
      chk("R12 idle hold", int'(sreg), int'(held));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule